// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two component predictors and a selector. The first component is a per-address table of 2-bit saturating counters. The second is a table indexed by a global outcome history combined by XOR with address bits. A third table of 2-bit counters, indexed by the address, decides which of the two components supplies the final direction. Each counter in the selector learns from the cases where one component was right and the other was wrong.

The fetch side presents a branch address and gets back the final direction, both component directions and the history-based index, all in the same cycle. The execution side later returns the resolved outcome, along with the component directions and history index that were recorded at prediction time. That resolve trains both components. It also trains the selector when exactly one component was correct, and it shifts the outcome into the 12-bit global history. The history is updated only at resolution; it is never updated speculatively.

Top module: `tourney_predictor`

## Requirements
- R1: After reset every component counter holds 2'b10 (weakly taken), every selector counter holds 2'b01 (weakly favouring the history component), and the global history is zero. A prediction right after reset is therefore taken from both components, `pred_use_bim`=0, and `pred_gsh_idx` equals address bits [13:2].
- R2: The per-address component is indexed by address bits [11:2] (1024 entries).
- R3: The history component is indexed by the global history XOR address bits [13:2] (4096 entries), and this index is output on `pred_gsh_idx`.
- R4: Counters use 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken, and predict from the MSB. A taken outcome increments a counter, saturating at 11; a not-taken outcome decrements it, saturating at 00.
- R5: The selector counter, indexed by address bits [11:2], increments when the stored per-address direction matched the outcome and the stored history direction did not, and decrements in the opposite case. It is unchanged when both matched or both missed, and it saturates at 00 and 11.
- R6: A selector MSB of 1 makes `pred_taken` follow the per-address component; an MSB of 0 makes it follow the history component.
- R7: Each resolve shifts the outcome into the global history LSB, dropping the oldest bit. Without a resolve the history is unchanged.
- R8: The history component is trained at the index given on `res_gsh_idx`, not at an index recomputed from the current history.
- R9: On every resolve both components are trained, whichever one was selected.
- R10: Predictions are combinational from the table state before the clock edge. A resolve is first visible in the prediction of the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_addr | input | 32 | Address of the branch being predicted |
| pred_taken | output | 1 | Final predicted direction |
| pred_bim | output | 1 | Per-address component direction |
| pred_gsh | output | 1 | History component direction |
| pred_use_bim | output | 1 | Selector picked the per-address component |
| pred_gsh_idx | output | 12 | History component index used for this prediction |
| resolve_valid | input | 1 | A resolved conditional branch is presented |
| res_addr | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Actual outcome |
| res_bim_pred | input | 1 | Per-address direction recorded at prediction |
| res_gsh_pred | input | 1 | History direction recorded at prediction |
| res_gsh_idx | input | 12 | History index recorded at prediction |

## Verification
The bench drives counters into both saturation limits. A design that wrapped around instead of saturating would flip a strong-taken counter to not-taken. The selector is driven through the cases where both components agree and where they disagree. A design that trained it on agreement would drift its choice without cause and change `pred_use_bim`. The history component is trained at a stored index that differs from the current one, which exposes a design that recomputes the index at resolve time. A prediction in the same cycle as a resolve must still show the old counters; a design that forwards the new value would change the direction one cycle early.

// File: rtl/tp_pkg.sv
package tp_pkg;
   typedef logic [1:0] ctr2_t;

   localparam ctr2_t CTR_WEAK_NT = 2'b01;
   localparam ctr2_t CTR_WEAK_T  = 2'b10;

   // one saturating step of a 2-bit counter
   function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
      ctr2_t n;
      if (up) n = (c == 2'b11) ? c : c + 2'b01;
      else    n = (c == 2'b00) ? c : c - 2'b01;
      return n;
   endfunction
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
   import tp_pkg::*;
#(
   parameter int    IDX_W = 10,
   parameter ctr2_t INIT  = CTR_WEAK_T
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output ctr2_t            rd_ctr,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic             upd_up
);
   localparam int DEPTH = 1 << IDX_W;

   if (IDX_W < 1 || IDX_W > 14) begin : g_bad_idx
      $error("tp_ctr_table: IDX_W out of range");
   end

   ctr2_t cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= INIT;
      end else if (upd_en) begin
         cells[upd_idx] <= ctr_step(cells[upd_idx], upd_up);
      end
   end

   assign rd_ctr = cells[rd_idx];
endmodule

// File: rtl/tp_ghr.sv
module tp_ghr #(
   parameter int HIST_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              shift_bit,
   output logic [HIST_W-1:0] hist
);
   if (HIST_W < 2) begin : g_bad_hist
      $error("tp_ghr: HIST_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hist <= '0;
      else if (shift_en) hist <= {hist[HIST_W-2:0], shift_bit};
   end
endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor
   import tp_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int ADDR_LSB = 2,
   parameter int HIST_W   = 12,
   parameter int LOC_W    = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] pred_addr,
   output logic              pred_taken,
   output logic              pred_bim,
   output logic              pred_gsh,
   output logic              pred_use_bim,
   output logic [HIST_W-1:0] pred_gsh_idx,
   input  logic              resolve_valid,
   input  logic [ADDR_W-1:0] res_addr,
   input  logic              res_taken,
   input  logic              res_bim_pred,
   input  logic              res_gsh_pred,
   input  logic [HIST_W-1:0] res_gsh_idx
);
   localparam int MAX_W = (HIST_W > LOC_W) ? HIST_W : LOC_W;

   if (ADDR_LSB + MAX_W > ADDR_W) begin : g_bad_addr
      $error("tourney_predictor: address too narrow for the index fields");
   end

   logic [HIST_W-1:0] ghr;
   logic [LOC_W-1:0]  loc_rd_idx, loc_up_idx;
   ctr2_t             bim_ctr, gsh_ctr, cho_ctr;
   logic              bim_ok, gsh_ok;

   assign loc_rd_idx   = pred_addr[ADDR_LSB +: LOC_W];
   assign loc_up_idx   = res_addr[ADDR_LSB +: LOC_W];
   assign pred_gsh_idx = ghr ^ pred_addr[ADDR_LSB +: HIST_W];

   assign bim_ok = (res_bim_pred == res_taken);
   assign gsh_ok = (res_gsh_pred == res_taken);

   tp_ctr_table #(.IDX_W(LOC_W), .INIT(CTR_WEAK_T)) u_bim (
      .clk, .rst_n,
      .rd_idx (loc_rd_idx),  .rd_ctr (bim_ctr),
      .upd_en (resolve_valid), .upd_idx (loc_up_idx), .upd_up (res_taken)
   );

   tp_ctr_table #(.IDX_W(HIST_W), .INIT(CTR_WEAK_T)) u_gsh (
      .clk, .rst_n,
      .rd_idx (pred_gsh_idx), .rd_ctr (gsh_ctr),
      .upd_en (resolve_valid), .upd_idx (res_gsh_idx), .upd_up (res_taken)
   );

   tp_ctr_table #(.IDX_W(LOC_W), .INIT(CTR_WEAK_NT)) u_cho (
      .clk, .rst_n,
      .rd_idx (loc_rd_idx), .rd_ctr (cho_ctr),
      .upd_en (resolve_valid && (bim_ok != gsh_ok)),
      .upd_idx (loc_up_idx), .upd_up (bim_ok)
   );

   tp_ghr #(.HIST_W(HIST_W)) u_ghr (
      .clk, .rst_n,
      .shift_en (resolve_valid), .shift_bit (res_taken), .hist (ghr)
   );

   assign pred_bim     = bim_ctr[1];
   assign pred_gsh     = gsh_ctr[1];
   assign pred_use_bim = cho_ctr[1];
   assign pred_taken   = pred_use_bim ? pred_bim : pred_gsh;
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
   parameter int ADDR_W = 32,
   parameter int HIST_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              resolve_valid,
   input logic              res_taken,
   input logic [HIST_W-1:0] ghr,
   input logic [ADDR_W-1:0] pred_addr,
   input logic              pred_bim,
   input logic              pred_gsh,
   input logic              pred_taken
);
   // R7
   hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resolve_valid |=> ghr == {$past(ghr[HIST_W-2:0]), $past(res_taken)});

   // R7
   hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !resolve_valid |=> $stable(ghr));

   // R6
   agree_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_bim == pred_gsh) |-> (pred_taken == pred_bim));

   // R10
   no_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !resolve_valid |=> (pred_addr != $past(pred_addr)) ||
         ($stable(pred_taken) && $stable(pred_bim) && $stable(pred_gsh)));
endmodule

bind tourney_predictor tp_checker #(.ADDR_W(ADDR_W), .HIST_W(HIST_W)) u_tp_chk (.*);

// File: tb/tb_tourney_predictor.sv
`timescale 1ns/100ps
module tb_tourney_predictor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pred_addr = '0;
   logic        pred_taken, pred_bim, pred_gsh, pred_use_bim;
   logic [11:0] pred_gsh_idx;
   logic        resolve_valid = 1'b0;
   logic [31:0] res_addr = '0;
   logic        res_taken = 1'b0, res_bim_pred = 1'b0, res_gsh_pred = 1'b0;
   logic [11:0] res_gsh_idx = '0;

   int checks = 0, failures = 0;

   // behavioural reference state
   int m_bim [1024];
   int m_gsh [4096];
   int m_cho [1024];
   int m_ghr;

   always #2.5 clk = ~clk;

   tourney_predictor dut (.*);

   function automatic int loc_of(input logic [31:0] a);
      return int'((a >> 2) & 32'h3FF);
   endfunction
   function automatic int gidx_of(input logic [31:0] a);
      return int'(((a >> 2) & 32'hFFF)) ^ m_ghr;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input logic [31:0] pa, input logic rv, input logic [31:0] ra,
                       input logic rt, input logic rb, input logic rg, input int ri);
      int eb, eg, ec;
      bit bok, gok;
      pred_addr = pa; resolve_valid = rv; res_addr = ra; res_taken = rt;
      res_bim_pred = rb; res_gsh_pred = rg; res_gsh_idx = ri[11:0];
      #1;
      eb = (m_bim[loc_of(pa)] >= 2) ? 1 : 0;
      eg = (m_gsh[gidx_of(pa)] >= 2) ? 1 : 0;
      ec = (m_cho[loc_of(pa)] >= 2) ? 1 : 0;
      chk("R2/R4 pred_bim", int'(pred_bim), eb);
      chk("R3/R4 pred_gsh", int'(pred_gsh), eg);
      chk("R5 pred_use_bim", int'(pred_use_bim), ec);
      chk("R6 pred_taken", int'(pred_taken), ec ? eb : eg);
      chk("R3/R7 pred_gsh_idx", int'(pred_gsh_idx), gidx_of(pa));
      @(posedge clk);
      if (rv) begin
         // R9: both components trained; R8: history table at stored index
         if (rt) begin
            if (m_bim[loc_of(ra)] < 3) m_bim[loc_of(ra)]++;
            if (m_gsh[ri] < 3) m_gsh[ri]++;
         end else begin
            if (m_bim[loc_of(ra)] > 0) m_bim[loc_of(ra)]--;
            if (m_gsh[ri] > 0) m_gsh[ri]--;
         end
         bok = (rb == rt); gok = (rg == rt);
         if (bok && !gok && m_cho[loc_of(ra)] < 3) m_cho[loc_of(ra)]++;
         if (!bok && gok && m_cho[loc_of(ra)] > 0) m_cho[loc_of(ra)]--;
         m_ghr = ((m_ghr << 1) | int'(rt)) & 32'hFFF;
      end
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] a, b, pool [8];
      foreach (m_bim[i]) m_bim[i] = 2;
      foreach (m_gsh[i]) m_gsh[i] = 2;
      foreach (m_cho[i]) m_cho[i] = 1;
      m_ghr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state seen at the ports
      pred_addr = 32'h0000_1234; #1;
      chk("R1 bim after reset", int'(pred_bim), 1);
      chk("R1 gsh after reset", int'(pred_gsh), 1);
      chk("R1 chooser after reset", int'(pred_use_bim), 0);
      chk("R1 index after reset", int'(pred_gsh_idx), int'((32'h1234 >> 2) & 12'hFFF));
      @(negedge clk);

      // R4: saturate up then down, both components correct or both wrong (R5 hold)
      a = 32'h0000_0400;
      for (int k = 0; k < 4; k++) step(a, 1'b1, a, 1'b1, 1'b1, 1'b1, gidx_of(a));
      step(a, 1'b0, a, 1'b0, 1'b0, 1'b0, 0);
      for (int k = 0; k < 5; k++) step(a, 1'b1, a, 1'b0, 1'b1, 1'b1, gidx_of(a));
      step(a, 1'b0, a, 1'b0, 1'b0, 1'b0, 0);

      // R5/R6: chooser climbs to bimodal and saturates, then falls back
      b = 32'h0000_0A08;
      for (int k = 0; k < 4; k++) step(b, 1'b1, b, 1'b1, 1'b1, 1'b0, gidx_of(b));
      step(b, 1'b0, b, 1'b0, 1'b0, 1'b0, 0);
      for (int k = 0; k < 5; k++) step(b, 1'b1, b, 1'b0, 1'b1, 1'b0, gidx_of(b));
      step(b, 1'b0, b, 1'b0, 1'b0, 1'b0, 0);

      // R8: train history table at a stored index unrelated to the current one
      for (int k = 0; k < 3; k++) step(32'h10, 1'b1, 32'h20, 1'b0, 1'b1, 1'b1, 12'hABC);
      step(32'((12'hABC ^ m_ghr[11:0]) << 2), 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 0);

      // R10: resolve and predict the same branch in one cycle
      step(a, 1'b1, a, 1'b1, 1'b0, 1'b1, gidx_of(a));
      step(a, 1'b0, a, 1'b0, 1'b0, 1'b0, 0);

      // mixed traffic over a small address pool
      foreach (pool[i]) pool[i] = 32'h0000_1000 + 32'(i) * 32'h44;
      for (int k = 0; k < 3000; k++) begin
         logic [31:0] p, r;
         p = pool[$urandom_range(7)];
         r = pool[$urandom_range(7)];
         step(p, 1'($urandom_range(3) != 0), r, 1'($urandom_range(1)),
              1'($urandom_range(1)), 1'($urandom_range(1)),
              ($urandom_range(1) != 0) ? gidx_of(r) : int'($urandom_range(4095)));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule